// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block generates the signal for one compare output pin of a 16-bit timer channel. It contains a free-running up-counter and a one-bit waveform register. On each clock it compares the counter with a compare value and with the active TOP value. A 4-bit waveform-mode code and a 2-bit compare-action field then decide whether the waveform register toggles, clears, sets or holds. The same inputs decide whether the pin shows that register or the ordinary port data bit.

Two families of waveform mode are covered. In the non-PWM family (free-running and clear-on-match), the compare-action field selects an action that fires on a compare match. In fast PWM, the same field selects an edge on match and the opposite edge at TOP. The toggle encoding is honoured in fast PWM only on the A channel, and only when TOP is user supplied; this is fixed by a parameter. A compare value equal to TOP is resolved in favour of the TOP action. The direction-enable bit drives the output-enable of the pin.

Top module: `tcw_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) forces the counter to 0 and the waveform register to 0.
- R2: The counter rises by one each clock and returns to 0 on the edge after it equals TOP. The 4-bit mode code (wgm_i) sets TOP as follows. For code 0, TOP is 0xFFFF. For codes 4, 12, 14 and 15, TOP is top_i. For codes 5, 6 and 7, TOP is 0x00FF, 0x01FF and 0x03FF.
- R3: In the non-PWM codes (0, 4, 12), com_i = 00 disconnects the waveform, so pin_o equals port_d_i.
- R4: In the non-PWM codes, a match (counter equal to ocr_i) acts on the waveform register at the following edge. com_i = 01 toggles it, 10 clears it and 11 sets it. The pin shows the register whenever com_i is not 00.
- R5: In the fast PWM codes (5, 6, 7, 14, 15), com_i = 10 clears the register on a match and sets it at TOP. com_i = 11 sets it on a match and clears it at TOP. Each action lands on the following edge.
- R6: In fast PWM with com_i = 01, the pin is connected and toggles on a match only when CHAN_A = 1 and wgm_i is 14 or 15. In every other case the pin equals port_d_i.
- R7: In fast PWM with ocr_i equal to TOP and com_i[1] = 1, the match is ignored and only the TOP action applies. As a result, com_i = 10 keeps the output high and 11 keeps it low.
- R8: pin_oe_o equals dir_en_i, so the pin is driven only while direction-enable is set.
- R9: While the waveform is disconnected, the waveform register holds its value. On reconnection, the pin resumes from the held value.
- R10: Any code outside R2's list is unsupported. For such a code, the counter runs to 0xFFFF and the pin equals port_d_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wgm_i | input | 4 | Waveform-mode code |
| com_i | input | 2 | Compare-action field |
| top_i | input | 16 | User TOP value |
| ocr_i | input | 16 | Compare value |
| dir_en_i | input | 1 | Direction-enable for the pin |
| port_d_i | input | 1 | Ordinary port data bit |
| cnt_o | output | 16 | Counter value |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The counter and the waveform register each change on the clock edge after the cycle in which the counter equals the compare value or TOP. pin_o and pin_oe_o follow the waveform register and the mode, port and enable inputs combinationally, within the same cycle. The bench drives inputs and samples on the falling edge. Its reference model advances on the rising edge from the same inputs, so every output is compared half a cycle after the edge that settled it.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    typedef enum logic [1:0] {
        WG_OFF    = 2'd0,
        WG_NONPWM = 2'd1,
        WG_FAST   = 2'd2
    } wg_class_e;

    typedef enum logic [1:0] {
        TS_MAX   = 2'd0,
        TS_INPUT = 2'd1,
        TS_FIXED = 2'd2
    } top_src_e;

    typedef enum logic [1:0] {
        CO_OFF    = 2'b00,
        CO_TOGGLE = 2'b01,
        CO_CLEAR  = 2'b10,
        CO_SET    = 2'b11
    } com_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_TOG  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_SET  = 2'd3
    } wf_act_e;

    typedef struct packed {
        wg_class_e  cls;
        top_src_e   src;
        logic [1:0] fixed_ext;   // fixed TOP = 2^(8+fixed_ext) - 1
        logic       tog_ok;      // user-TOP fast PWM permits toggle
    } wg_decode_t;

    function automatic wg_decode_t wg_decode(input logic [3:0] code);
        wg_decode_t d;
        d = '{cls: WG_OFF, src: TS_MAX, fixed_ext: 2'd0, tog_ok: 1'b0};
        case (code)
            4'd0:         d.cls = WG_NONPWM;
            4'd4, 4'd12:  begin d.cls = WG_NONPWM; d.src = TS_INPUT; end
            4'd5:         begin d.cls = WG_FAST; d.src = TS_FIXED; d.fixed_ext = 2'd0; end
            4'd6:         begin d.cls = WG_FAST; d.src = TS_FIXED; d.fixed_ext = 2'd1; end
            4'd7:         begin d.cls = WG_FAST; d.src = TS_FIXED; d.fixed_ext = 2'd2; end
            4'd14, 4'd15: begin d.cls = WG_FAST; d.src = TS_INPUT; d.tog_ok = 1'b1; end
            default:      d.cls = WG_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tcw_counter.sv
module tcw_counter
    import tcw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wg_decode_t       dec,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] top_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] fixed_top;
    logic [CNT_W-1:0] top_sel;

    always_comb begin
        fixed_top = CNT_W'((32'h100 << dec.fixed_ext) - 32'd1);
        case (dec.src)
            TS_INPUT: top_sel = top_i;
            TS_FIXED: top_sel = fixed_top;
            default:  top_sel = CNT_MAX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (cnt_q == top_sel) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign top_o = top_sel;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == top_sel) |=> (cnt_q == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != top_sel) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/tcw_wavegen.sv
module tcw_wavegen
    import tcw_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit CHAN_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  wg_decode_t       dec,
    input  logic [1:0]       com,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] ocr,
    output logic             wf_o,
    output logic             conn_o
);
    logic    wf_q;
    logic    match;
    logic    at_top;
    logic    tog_allowed;
    logic    conn;
    wf_act_e act;

    generate
        if (CHAN_A) begin : g_chan_a
            assign tog_allowed = dec.tog_ok;
        end else begin : g_chan_b
            assign tog_allowed = 1'b0;
        end
    endgenerate

    always_comb begin
        match  = (cnt == ocr);
        at_top = (cnt == top);
        case (dec.cls)
            WG_NONPWM: conn = (com != CO_OFF);
            WG_FAST:   conn = com[1] | ((com == CO_TOGGLE) & tog_allowed);
            default:   conn = 1'b0;
        endcase
    end

    always_comb begin
        act = ACT_NONE;
        if (conn) begin
            if (dec.cls == WG_NONPWM) begin
                if (match) begin
                    case (com)
                        CO_TOGGLE: act = ACT_TOG;
                        CO_CLEAR:  act = ACT_CLR;
                        CO_SET:    act = ACT_SET;
                        default:   act = ACT_NONE;
                    endcase
                end
            end else if (com[1]) begin
                // TOP action takes precedence: a match at TOP is dropped
                if (at_top)     act = (com == CO_CLEAR) ? ACT_SET : ACT_CLR;
                else if (match) act = (com == CO_CLEAR) ? ACT_CLR : ACT_SET;
            end else if (match) begin
                act = ACT_TOG;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wf_q <= 1'b0;
        else begin
            case (act)
                ACT_TOG: wf_q <= ~wf_q;
                ACT_CLR: wf_q <= 1'b0;
                ACT_SET: wf_q <= 1'b1;
                default: wf_q <= wf_q;
            endcase
        end
    end

    assign wf_o   = wf_q;
    assign conn_o = conn;

    AST_NP_SET: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_NONPWM && com == CO_SET && cnt == ocr) |=> wf_q); // R4
    AST_NP_CLR: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_NONPWM && com == CO_CLEAR && cnt == ocr) |=> !wf_q); // R4
    AST_FP_TOP_SET: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_FAST && com == CO_CLEAR && cnt == top) |=> wf_q); // R5
    AST_FP_TOP_CLR: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_FAST && com == CO_SET && cnt == top) |=> !wf_q); // R5
    AST_OCR_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_FAST && com == CO_CLEAR && ocr == top && cnt == ocr) |=> wf_q); // R7
    AST_DISC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dec.cls == WG_OFF || com == CO_OFF) |=> $stable(wf_q)); // R9

endmodule

// File: rtl/tcw_pinmux.sv
module tcw_pinmux (
    input  logic conn,
    input  logic wf,
    input  logic port_d,
    input  logic dir_en,
    output logic pin,
    output logic pin_oe
);
    assign pin    = conn ? wf : port_d;
    assign pin_oe = dir_en;
endmodule

// File: rtl/tcw_unit.sv
module tcw_unit
    import tcw_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter bit CHAN_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       wgm_i,
    input  logic [1:0]       com_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] ocr_i,
    input  logic             dir_en_i,
    input  logic             port_d_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    wg_decode_t       dec;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_act;
    logic             wf;
    logic             conn;

    assign dec = wg_decode(wgm_i);

    tcw_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .top_i (top_i),
        .cnt_o (cnt),
        .top_o (top_act)
    );

    tcw_wavegen #(.CNT_W(CNT_W), .CHAN_A(CHAN_A)) u_wavegen (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .com    (com_i),
        .cnt    (cnt),
        .top    (top_act),
        .ocr    (ocr_i),
        .wf_o   (wf),
        .conn_o (conn)
    );

    tcw_pinmux u_pinmux (
        .conn   (conn),
        .wf     (wf),
        .port_d (port_d_i),
        .dir_en (dir_en_i),
        .pin    (pin_o),
        .pin_oe (pin_oe_o)
    );

    assign cnt_o = cnt;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt_o == '0)); // R1

endmodule

// File: tb/tcw_unit_tb.sv
module tcw_unit_tb;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  wgm;
    logic [1:0]  com;
    logic [15:0] top, ocr;
    logic        dir_en, port_d;
    logic [15:0] cnt_a, cnt_b;
    logic        pin_a, pin_b, oe_a, oe_b;

    int    n_chk  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    int cnt_m = 0;
    bit wfa_m = 0, wfb_m = 0;

    always #(TCK/2) clk = ~clk;

    tcw_unit #(.CNT_W(16), .CHAN_A(1'b1)) u_dut (
        .clk(clk), .rst(rst), .wgm_i(wgm), .com_i(com), .top_i(top), .ocr_i(ocr),
        .dir_en_i(dir_en), .port_d_i(port_d), .cnt_o(cnt_a), .pin_o(pin_a), .pin_oe_o(oe_a));

    tcw_unit #(.CNT_W(16), .CHAN_A(1'b0)) u_dut_b (
        .clk(clk), .rst(rst), .wgm_i(wgm), .com_i(com), .top_i(top), .ocr_i(ocr),
        .dir_en_i(dir_en), .port_d_i(port_d), .cnt_o(cnt_b), .pin_o(pin_b), .pin_oe_o(oe_b));

    // ---- behavioural reference ----
    function automatic int m_top(int code, int t);
        if (code == 4 || code == 12 || code == 14 || code == 15) return t;
        if (code == 5) return 255;
        if (code == 6) return 511;
        if (code == 7) return 1023;
        return 65535;
    endfunction

    function automatic bit m_fast(int code);
        return (code >= 5 && code <= 7) || code == 14 || code == 15;
    endfunction

    function automatic bit m_nonpwm(int code);
        return code == 0 || code == 4 || code == 12;
    endfunction

    function automatic bit m_conn(int code, int c, bit ch_a);
        if (m_nonpwm(code)) return c != 0;
        if (m_fast(code))   return c >= 2 || (c == 1 && ch_a && code >= 14);
        return 0;
    endfunction

    function automatic bit m_next(bit w, int code, int c, int k, int t, int o, bit ch_a);
        if (!m_conn(code, c, ch_a)) return w;
        if (m_nonpwm(code)) begin
            if (k != o) return w;
            if (c == 1) return !w;
            return c == 3;
        end
        if (c >= 2) begin
            if (k == t) return c == 2;
            if (k == o) return c == 3;
            return w;
        end
        return (k == o) ? !w : w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            cnt_m = 0; wfa_m = 0; wfb_m = 0;
        end else begin
            int t;
            t = m_top(wgm, top);
            wfa_m = m_next(wfa_m, wgm, com, cnt_m, t, ocr, 1'b1);
            wfb_m = m_next(wfb_m, wgm, com, cnt_m, t, ocr, 1'b0);
            cnt_m = (cnt_m == t) ? 0 : (cnt_m + 1) % 65536;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            bit ea, eb;
            @(negedge clk);
            ea = m_conn(wgm, com, 1'b1) ? wfa_m : port_d;
            eb = m_conn(wgm, com, 1'b0) ? wfb_m : port_d;
            chk(cnt_a == cnt_m, "counter", cnt_a, cnt_m);
            chk(pin_a == ea, "pin A", pin_a, ea);
            chk(pin_b == eb, "pin B", pin_b, eb);
            chk(oe_a == dir_en && oe_b == dir_en, "oe", oe_a, dir_en); // R8
        end
    endtask

    initial begin
        #(TCK * 300000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1; wgm = 4; com = 2'b11; top = 9; ocr = 3; dir_en = 1; port_d = 1;
        tag = "R1"; step(3);
        chk(cnt_a == 0 && pin_a == 0, "R1 reset state", pin_a, 0);
        rst = 0;
        tag = "R4"; com = 2'b01; step(40);
        com = 2'b10; step(20);
        com = 2'b11; step(20);
        tag = "R3"; com = 2'b00; step(5); port_d = 0; step(5);
        chk(pin_a == 0, "R3 port pass", pin_a, 0);
        tag = "R9"; port_d = 1; com = 2'b00; step(7);
        com = 2'b01; step(12);
        tag = "R5"; wgm = 14; top = 19; ocr = 7; com = 2'b10; step(60);
        com = 2'b11; step(60);
        tag = "R7"; ocr = 19; com = 2'b10; step(45);
        com = 2'b11; step(45);
        tag = "R6"; wgm = 15; ocr = 4; com = 2'b01; port_d = 0; step(50);
        wgm = 5; step(30);
        tag = "R2"; com = 2'b10; ocr = 100; step(600);
        wgm = 7; step(2100);
        tag = "R8"; dir_en = 0; step(5); dir_en = 1; step(3);
        tag = "R10"; wgm = 2; com = 2'b11; port_d = 1; step(20);
        tag = "R1"; rst = 1; step(2); rst = 0;
        tag = "R2"; wgm = 0; com = 2'b01; ocr = 10; step(65545);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule